// File: doc/BRIEF.md
# Array Write-Protect Controller

This block decides, for every write the serial slave wants to place into a 256-byte array, whether that write may touch the array. Two sources of protection combine. A hardware protect pin, when high, freezes the whole array. A software lock flag, once set, freezes the lower half (addresses 00h to 7Fh) and leaves the upper half alone. The flag is armed by a dedicated control command. It can be disarmed only by a qualified unlock sequence that needs a high-voltage indication on the protect pin, held for a programmable number of cycles.

The block sits behind a slave front end that already detects start and stop conditions, filters by chip-select, shifts bytes and runs the write-cycle timer. The front end hands over one-cycle event pulses: a control byte (upper nibble and R/W bit), an address byte, a data byte, a stop condition, and the end of an internal write cycle. It reads back a write-allowed decision for the address it presents and an acknowledge decision for the protect command. A flag change never takes effect at once. It is held pending, and the block reports busy, until the write cycle that carries the change completes.

Top module: `wp_guard`

## Requirements
- R1: After reset the lock flag reads 0, busy reads 0, and with the protect pin low every address is write-allowed.
- R2: While the protect pin is high, no address is write-allowed, whatever the flag.
- R3: With the protect pin low and the flag set, addresses whose most significant bit is 0 (00h-7Fh) are refused and addresses 80h-FFh are allowed.
- R4: `prot_ack` is high during a control-byte event with nibble 0110 and R/W = 0 only when the flag is clear and no flag change is pending. It is low for nibble 0110 with R/W = 1 and whenever the flag is set.
- R5: An acknowledged 0110 write command ended by a stop, whatever its address and data bytes, makes busy read 1 from the cycle after the stop. On the end-of-write-cycle pulse the flag becomes 1 and busy returns to 0.
- R6: If the protect pin is high when the stop of a 0110 command arrives, the flag is not set and busy stays 0.
- R7: While a change is pending, the flag and the write-allowed decision keep their old values. The flag changes only on an end-of-write-cycle pulse.
- R8: The flag clears after the end of the write cycle that follows this exact sequence: control nibble 1001, then control nibble 1010 with R/W = 0, address byte 09h, data byte FFh, and a stop. The high-voltage flag must have been high for at least HV_HOLD cycles when the 1001 byte arrives and must still be high at the stop.
- R9: An unlock sequence sent before the high-voltage hold count is reached is ignored: busy stays 0 and the flag stays set.
- R10: An unlock sequence with a wrong address or data byte is ignored.
- R11: A normal 1010 write that is not preceded by the 1001 prefix never clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_wp | input | 1 | Hardware protect pin level (1 = protect all) |
| hv_present | input | 1 | High-voltage detected on the protect pin |
| ev_ctl | input | 1 | Pulse: control byte received (chip-select already matched) |
| ev_code | input | 4 | Upper nibble of that control byte |
| ev_rw | input | 1 | R/W bit of that control byte (1 = read) |
| ev_addr | input | 1 | Pulse: word-address byte received |
| ev_data | input | 1 | Pulse: data byte received |
| ev_byte | input | 8 | Value of the address or data byte |
| ev_stop | input | 1 | Pulse: stop condition |
| wc_done | input | 1 | Pulse: internal write cycle finished |
| wr_addr | input | 8 | Address the front end wants to write |
| wr_allow | output | 1 | Write to wr_addr is permitted |
| prot_ack | output | 1 | Acknowledge decision for the protect control byte |
| lock_flag | output | 1 | Current lower-half lock flag |
| lock_busy | output | 1 | A flag change is pending |

## Verification
The assertions assume the event inputs are single-cycle pulses, at most one per cycle. They assume that an end-of-write-cycle pulse arrives only after a stop has started a cycle, and that the high-voltage flag is a clean level. The bench drives every event for exactly one cycle on the falling edge, spaces events by at least one idle cycle, and raises `wc_done` only after a stop. It holds `hv_present` steady across each unlock attempt. It changes it only between sequences, so the hold counter sees monotonic intervals.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam logic [3:0] CODE_MEM  = 4'b1010;
  localparam logic [3:0] CODE_LOCK = 4'b0110;
  localparam logic [3:0] CODE_PFX  = 4'b1001;
  localparam logic [7:0] UNLOCK_ADDR = 8'h09;
  localparam logic [7:0] UNLOCK_DATA = 8'hFF;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LOCK_ARM,
    SQ_PFX,
    SQ_UCTL,
    SQ_UADDR,
    SQ_UDATA
  } seq_e;
endpackage

// File: rtl/wp_hv_qual.sv
module wp_hv_qual #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hv_in,
  output logic hv_ok
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!hv_in)
      cnt_d = '0;
    else if (cnt_q != CW'(HOLD))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hv_ok = (cnt_q == CW'(HOLD));

  // R9: qualification is only reported after the level has been seen
  a_r9_ok_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
    hv_ok |-> $past(hv_in));
endmodule

// File: rtl/wp_cmd_seq.sv
module wp_cmd_seq
  import wp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_wp,
  input  logic       hv_ok,
  input  logic       lock_flag,
  input  logic       busy,
  input  logic       ev_ctl,
  input  logic [3:0] ev_code,
  input  logic       ev_rw,
  input  logic       ev_addr,
  input  logic       ev_data,
  input  logic [7:0] ev_byte,
  input  logic       ev_stop,
  output logic       prot_ack,
  output logic       req_set,
  output logic       req_clr
);
  seq_e st_q, st_d;

  always_comb begin
    prot_ack = ev_ctl && (ev_code == CODE_LOCK) && !ev_rw && !lock_flag && !busy;
  end

  always_comb begin
    st_d = st_q;
    if (ev_stop) begin
      st_d = SQ_IDLE;
    end else if (ev_ctl) begin
      if (prot_ack)
        st_d = SQ_LOCK_ARM;
      else if ((ev_code == CODE_PFX) && hv_ok)
        st_d = SQ_PFX;
      else if ((st_q == SQ_PFX) && (ev_code == CODE_MEM) && !ev_rw)
        st_d = SQ_UCTL;
      else
        st_d = SQ_IDLE;
    end else if (ev_addr) begin
      if ((st_q == SQ_UCTL) && (ev_byte == UNLOCK_ADDR))
        st_d = SQ_UADDR;
      else if (st_q != SQ_LOCK_ARM)
        st_d = SQ_IDLE;
    end else if (ev_data) begin
      if ((st_q == SQ_UADDR) && (ev_byte == UNLOCK_DATA))
        st_d = SQ_UDATA;
      else if (st_q != SQ_LOCK_ARM)
        st_d = SQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign req_set = ev_stop && (st_q == SQ_LOCK_ARM) && !hw_wp;
  assign req_clr = ev_stop && (st_q == SQ_UDATA) && hv_ok;

  // R8: the unlock data state is only reached from the address state
  a_r8_order: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_UDATA) && !$stable(st_q) |-> $past(st_q) == SQ_UADDR);
endmodule

// File: rtl/wp_flag_reg.sv
module wp_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic req_set,
  input  logic req_clr,
  input  logic wc_done,
  output logic flag,
  output logic busy
);
  logic flag_q, flag_d;
  logic pset_q, pset_d;
  logic pclr_q, pclr_d;
  logic pend_en;

  assign busy    = pset_q | pclr_q;
  assign pend_en = !busy && (req_set || req_clr);

  always_comb begin
    flag_d = flag_q;
    pset_d = pset_q;
    pclr_d = pclr_q;
    if (wc_done) begin
      if (pset_q)      flag_d = 1'b1;
      else if (pclr_q) flag_d = 1'b0;
      pset_d = 1'b0;
      pclr_d = 1'b0;
    end else if (pend_en) begin
      pset_d = req_set;
      pclr_d = req_clr && !req_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      pset_q <= 1'b0;
      pclr_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      pset_q <= pset_d;
      pclr_q <= pclr_d;
    end
  end

  assign flag = flag_q;

  a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wc_done |=> $stable(flag));
  a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !wc_done |=> busy);
endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int ADDR_W  = 8,
  parameter int HV_HOLD = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_wp,
  input  logic              hv_present,
  input  logic              ev_ctl,
  input  logic [3:0]        ev_code,
  input  logic              ev_rw,
  input  logic              ev_addr,
  input  logic              ev_data,
  input  logic [7:0]        ev_byte,
  input  logic              ev_stop,
  input  logic              wc_done,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              wr_allow,
  output logic              prot_ack,
  output logic              lock_flag,
  output logic              lock_busy
);
  logic rs_q1, rs_q2;
  logic hv_ok, req_set, req_clr;
  logic low_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end

  wp_hv_qual #(.HOLD(HV_HOLD)) u_hv (
    .clk(clk), .rst_n(rs_q2), .hv_in(hv_present), .hv_ok(hv_ok)
  );

  wp_cmd_seq u_seq (
    .clk(clk), .rst_n(rs_q2), .hw_wp(hw_wp), .hv_ok(hv_ok),
    .lock_flag(lock_flag), .busy(lock_busy),
    .ev_ctl(ev_ctl), .ev_code(ev_code), .ev_rw(ev_rw),
    .ev_addr(ev_addr), .ev_data(ev_data), .ev_byte(ev_byte),
    .ev_stop(ev_stop), .prot_ack(prot_ack),
    .req_set(req_set), .req_clr(req_clr)
  );

  wp_flag_reg u_flag (
    .clk(clk), .rst_n(rs_q2), .req_set(req_set), .req_clr(req_clr),
    .wc_done(wc_done), .flag(lock_flag), .busy(lock_busy)
  );

  assign low_half = !wr_addr[ADDR_W-1];
  assign wr_allow = !hw_wp && !(lock_flag && low_half);

  a_r4_locked_no_ack: assert property (@(posedge clk) disable iff (!rs_q2)
    lock_flag |-> !prot_ack);
  a_r5_set_after_pend: assert property (@(posedge clk) disable iff (!rs_q2)
    $rose(lock_flag) |-> $past(lock_busy));
  a_r8_clr_after_pend: assert property (@(posedge clk) disable iff (!rs_q2)
    $fell(lock_flag) |-> $past(lock_busy));
  a_r9_clr_needs_hv: assert property (@(posedge clk) disable iff (!rs_q2)
    req_clr |-> hv_present);
endmodule

// File: tb/wp_guard_test.sv
`timescale 1ns/1ps
module wp_guard_test;
  logic clk = 1'b0;
  logic rst_n;
  logic hw_wp, hv_present, ev_ctl, ev_rw, ev_addr, ev_data, ev_stop, wc_done;
  logic [3:0] ev_code;
  logic [7:0] ev_byte, wr_addr;
  logic wr_allow, prot_ack, lock_flag, lock_busy;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wp_guard #(.ADDR_W(8), .HV_HOLD(8)) uut (
    .clk(clk), .rst_n(rst_n), .hw_wp(hw_wp), .hv_present(hv_present),
    .ev_ctl(ev_ctl), .ev_code(ev_code), .ev_rw(ev_rw), .ev_addr(ev_addr),
    .ev_data(ev_data), .ev_byte(ev_byte), .ev_stop(ev_stop),
    .wc_done(wc_done), .wr_addr(wr_addr), .wr_allow(wr_allow),
    .prot_ack(prot_ack), .lock_flag(lock_flag), .lock_busy(lock_busy)
  );

  // {wp, addr, expect with flag clear, expect with flag set}
  localparam logic [10:0] VEC [0:7] = '{
    {1'b0, 8'h00, 1'b1, 1'b0},
    {1'b0, 8'h7F, 1'b1, 1'b0},
    {1'b0, 8'h80, 1'b1, 1'b1},
    {1'b0, 8'hFF, 1'b1, 1'b1},
    {1'b1, 8'h00, 1'b0, 1'b0},
    {1'b1, 8'h80, 1'b0, 1'b0},
    {1'b1, 8'hFF, 1'b0, 1'b0},
    {1'b0, 8'h40, 1'b1, 1'b0}
  };

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ctl(input logic [3:0] code, input logic rw, output logic ack);
    ev_ctl = 1'b1; ev_code = code; ev_rw = rw;
    #1 ack = prot_ack;
    @(negedge clk); ev_ctl = 1'b0;
    @(negedge clk);
  endtask

  task automatic abyte(input logic [7:0] b);
    ev_addr = 1'b1; ev_byte = b;
    @(negedge clk); ev_addr = 1'b0;
    @(negedge clk);
  endtask

  task automatic dbyte(input logic [7:0] b);
    ev_data = 1'b1; ev_byte = b;
    @(negedge clk); ev_data = 1'b0;
    @(negedge clk);
  endtask

  task automatic stop();
    ev_stop = 1'b1;
    @(negedge clk); ev_stop = 1'b0;
  endtask

  task automatic wcycle();
    wc_done = 1'b1;
    @(negedge clk); wc_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic walk(input bit flagset, input string req);
    for (int i = 0; i < 8; i++) begin
      hw_wp = VEC[i][10]; wr_addr = VEC[i][9:2];
      #1 check(wr_allow, flagset ? VEC[i][0] : VEC[i][1], req);
      @(negedge clk);
    end
    hw_wp = 1'b0;
  endtask

  task automatic unlock(input logic [7:0] a, input logic [7:0] d);
    logic k;
    ctl(4'b1001, 1'b0, k);
    ctl(4'b1010, 1'b0, k);
    abyte(a);
    dbyte(d);
    stop();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic ack;
    rst_n = 1'b0; hw_wp = 1'b0; hv_present = 1'b0; ev_ctl = 1'b0;
    ev_code = 4'h0; ev_rw = 1'b0; ev_addr = 1'b0; ev_data = 1'b0;
    ev_byte = 8'h00; ev_stop = 1'b0; wc_done = 1'b0; wr_addr = 8'h00;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    check(lock_flag, 1'b0, "R1 flag");
    check(lock_busy, 1'b0, "R1 busy");
    wr_addr = 8'h00; #1 check(wr_allow, 1'b1, "R1 allow");
    @(negedge clk);

    // R2 / R3 table with flag clear
    walk(1'b0, "R2/R3 flag clear");

    // R4 acknowledge rules
    ctl(4'b0110, 1'b1, ack); check(ack, 1'b0, "R4 read nack");
    stop(); idle(1);
    ctl(4'b1010, 1'b0, ack); check(ack, 1'b0, "R4 other code nack");
    stop(); idle(1);

    // R6 set attempt blocked by pin at stop
    ctl(4'b0110, 1'b0, ack); check(ack, 1'b1, "R4 ack");
    abyte(8'h00); dbyte(8'h00);
    hw_wp = 1'b1; stop(); hw_wp = 1'b0;
    check(lock_busy, 1'b0, "R6 busy");
    wcycle();
    check(lock_flag, 1'b0, "R6 flag");

    // R5 / R7 set with arbitrary bytes
    ctl(4'b0110, 1'b0, ack); check(ack, 1'b1, "R5 ack");
    abyte(8'h55); dbyte(8'h12); dbyte(8'hA7);
    stop();
    check(lock_busy, 1'b1, "R5 busy");
    check(lock_flag, 1'b0, "R7 flag old");
    wr_addr = 8'h10; #1 check(wr_allow, 1'b1, "R7 allow old");
    idle(3);
    ctl(4'b0110, 1'b0, ack); check(ack, 1'b0, "R4 busy nack");
    wcycle();
    check(lock_flag, 1'b1, "R5 flag set");
    check(lock_busy, 1'b0, "R5 busy clear");

    // R2 / R3 table with flag set
    walk(1'b1, "R2/R3 flag set");

    ctl(4'b0110, 1'b0, ack); check(ack, 1'b0, "R4 locked nack");
    stop(); idle(1);

    // R11 plain write of the unlock bytes
    ctl(4'b1010, 1'b0, ack); abyte(8'h09); dbyte(8'hFF); stop();
    check(lock_busy, 1'b0, "R11 busy");
    wcycle();
    check(lock_flag, 1'b1, "R11 flag");

    // R9 hold not reached (3 cycles of 8)
    hv_present = 1'b1; idle(3);
    unlock(8'h09, 8'hFF);
    check(lock_busy, 1'b0, "R9 busy");
    wcycle();
    check(lock_flag, 1'b1, "R9 flag");
    hv_present = 1'b0; idle(2);

    // R10 wrong address / wrong data
    hv_present = 1'b1; idle(12);
    unlock(8'h0A, 8'hFF);
    check(lock_busy, 1'b0, "R10 addr busy");
    unlock(8'h09, 8'hFE);
    check(lock_busy, 1'b0, "R10 data busy");
    wcycle();
    check(lock_flag, 1'b1, "R10 flag");

    // R8 correct unlock
    unlock(8'h09, 8'hFF);
    check(lock_busy, 1'b1, "R8 busy");
    check(lock_flag, 1'b1, "R8 flag pending");
    wcycle();
    check(lock_flag, 1'b0, "R8 flag cleared");
    hv_present = 1'b0;
    wr_addr = 8'h10; #1 check(wr_allow, 1'b1, "R8 allow low half");
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule